// File: doc/BRIEF.md
# NOR Flash Boot Header Loader

At boot, this block reads the first words of a parallel NOR flash over a simple asynchronous memory strobe. It does not know the flash width beforehand. It first reads four single bytes at 8-bit width and packs them into a configuration word. It then checks that every reserved bit of that word is zero. If the word is clean, its width bit selects 8-bit or 16-bit accesses for the rest of the fetch. The loader then reads a 32-bit marker word, which must match a fixed magic constant. After that it reads the first command word and hands it on.

Any reserved bit that is set means the header was misread, so the loader stops with a header error code. A common cause is a wide device seen through a narrow lane, where duplicated low bytes or pulled-up upper bytes appear. A wrong marker word stops the loader with a different code. Both outcomes, together with a done flag and an error flag, hold until the next reset.

The first command word leaves the block on a valid/ready pair. `op_valid` rises with the word and stays high until a cycle in which `op_ready` is also high. During back-pressure `op_data` holds its value. The loader makes no further flash accesses after the header, marker and command words.

Top module: `nor_hdr_loader`

## Requirements
- R1: After reset the first four accesses use byte addresses 0, 1, 2 and 3, and each access takes only `fl_rdata[7:0]`; the upper data byte is ignored.
- R2: The four header bytes are packed little-endian (first byte in bits 7:0) and shown on `cfg_word`.
- R3: Configuration bit 0 selects the width. With 1, `wide16` goes high and each later word comes from two 16-bit reads at halfword addresses 2,3 then 4,5, low halfword first. With 0, later words come from byte reads at addresses 4 to 11, lowest byte first.
- R4: If any of configuration bits 31:12, 7:6 or 3:1 is one, `status` becomes 5, `err` rises and no further access is made. This includes duplicated low bytes (0x00002121) and pulled-up upper bytes.
- R5: Bits 5:4 (boot method) and 11:8 (copy field) of the configuration word do not affect acceptance.
- R6: The word after the header must equal 0x41504954. Any other value sets `status` to 6, raises `err` and stops further accesses.
- R7: The word after the marker appears on `op_data` with `op_valid` high, and `done` rises at the same time. `op_valid` and `op_data` hold until accepted with `op_ready`, after which `op_valid` falls.
- R8: Each access holds `fl_cs_n` low for exactly `wait_cycles`+1 cycles, with `fl_addr` stable, and `fl_cs_n` is high for at least one cycle between accesses.
- R9: `status` reads 0 while the loader runs and after success. `status`, `done` and `err` hold until reset, and `done` and `err` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; a new boot fetch starts on release |
| wait_cycles | input | WAIT_W | Extra strobe cycles per access |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_addr | output | ADDR_W | Byte address (8-bit mode) or halfword address (16-bit mode) |
| fl_rdata | input | 16 | Flash read data |
| cfg_word | output | 32 | Packed configuration word |
| wide16 | output | 1 | 16-bit accesses selected |
| op_valid | output | 1 | First command word available |
| op_ready | input | 1 | Consumer accepts the command word |
| op_data | output | 32 | First command word |
| done | output | 1 | Command word fetched |
| err | output | 1 | Boot aborted |
| status | output | 32 | 0 running/ok, 5 header misread, 6 marker mismatch |

## Verification
Header images are presented in both widths, with different wait-state counts. The 16-bit run pads header beats with 0xFF in the upper lane, which separates correct byte-lane selection from use of the full bus. A header with method and copy bits set shows that only the reserved mask matters. Duplicated low bytes, pulled-up upper bytes and single stray reserved bits must each give code 5 after exactly four accesses. A corrupt marker must give code 6 after the marker reads and before any command read. The access address sequence and the strobe lengths are logged for every run, and the command word is held under back-pressure to test its stability.

// File: rtl/nor_hdr_pkg.sv
package nor_hdr_pkg;
  localparam int WORD_W = 32;
  localparam int BEAT_W = 16;
  localparam logic [WORD_W-1:0] HDR_RSVD_MASK = 32'hFFFF_F0CE;
  localparam logic [WORD_W-1:0] BOOT_MAGIC    = 32'h4150_4954;
  localparam logic [WORD_W-1:0] ST_OK         = 32'd0;
  localparam logic [WORD_W-1:0] ST_HDR_BAD    = 32'd5;
  localparam logic [WORD_W-1:0] ST_MAGIC_BAD  = 32'd6;

  typedef enum logic [2:0] {
    PH_HDR, PH_MAGIC, PH_OP, PH_OFFER, PH_DONE, PH_FAIL
  } phase_t;
endpackage

// File: rtl/nhl_bus_port.sv
module nhl_bus_port import nor_hdr_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              cs_n,
  output logic [ADDR_W-1:0] addr,
  input  logic [BEAT_W-1:0] rdata,
  output logic              beat_valid,
  output logic [BEAT_W-1:0] beat_data
);
  logic              busy;
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      addr       <= '0;
      beat_valid <= 1'b0;
      beat_data  <= '0;
    end else begin
      beat_valid <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy <= 1'b1;
          cnt  <= wait_cycles;
          addr <= req_addr;
        end
      end else if (cnt == '0) begin
        busy       <= 1'b0;
        beat_valid <= 1'b1;
        beat_data  <= rdata;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cs_n = ~busy;

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));
  assert_strobe_ends_in_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> (!cs_n || beat_valid));
  assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> cs_n);
endmodule

// File: rtl/nhl_word_pack.sv
module nhl_word_pack import nor_hdr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  logic [1:0] part;
  logic [1:0] last_part;

  assign last_part = wide ? 2'd1 : 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part       <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (beat_valid) begin
        if (wide) word <= {beat_data, word[WORD_W-1:BEAT_W]};
        else      word <= {beat_data[7:0], word[WORD_W-1:8]};
        if (part == last_part) begin
          part       <= '0;
          word_valid <= 1'b1;
        end else begin
          part <= part + 2'd1;
        end
      end
    end
  end

  assert_part_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> (part <= 2'd1));
endmodule

// File: rtl/nhl_hdr_check.sv
module nhl_hdr_check import nor_hdr_pkg::*; (
  input  logic [WORD_W-1:0] cfg,
  output logic              hdr_ok,
  output logic              want16
);
  always_comb begin
    hdr_ok = ((cfg & HDR_RSVD_MASK) == '0);
    want16 = cfg[0];
  end
endmodule

// File: rtl/nor_hdr_loader.sv
module nor_hdr_loader import nor_hdr_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              fl_cs_n,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic [15:0]       fl_rdata,
  output logic [31:0]       cfg_word,
  output logic              wide16,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [31:0]       op_data,
  output logic              done,
  output logic              err,
  output logic [31:0]       status
);
  localparam logic [ADDR_W-1:0] HALF_START = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] BYTE_START = ADDR_W'(4);

  phase_t            phase;
  logic [ADDR_W-1:0] idx;
  logic [2:0]        left;
  logic              pend;
  logic              bus_req;
  logic              beat_valid, word_valid;
  logic [BEAT_W-1:0] beat_data;
  logic [WORD_W-1:0] word;
  logic              hdr_ok, want16;
  logic [2:0]        beats;

  assign beats   = wide16 ? 3'd2 : 3'd4;
  assign bus_req = (phase == PH_HDR || phase == PH_MAGIC || phase == PH_OP)
                   && (left != 3'd0) && !pend;

  nhl_bus_port #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .req_addr(idx),
    .wait_cycles(wait_cycles), .cs_n(fl_cs_n), .addr(fl_addr),
    .rdata(fl_rdata), .beat_valid(beat_valid), .beat_data(beat_data)
  );

  nhl_word_pack u_pack (
    .clk(clk), .rst_n(rst_n), .wide(wide16), .beat_valid(beat_valid),
    .beat_data(beat_data), .word_valid(word_valid), .word(word)
  );

  nhl_hdr_check u_chk (.cfg(word), .hdr_ok(hdr_ok), .want16(want16));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HDR;
      idx      <= '0;
      left     <= 3'd4;
      pend     <= 1'b0;
      wide16   <= 1'b0;
      cfg_word <= '0;
      op_data  <= '0;
      status   <= ST_OK;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (bus_req) begin
        pend <= 1'b1;
        idx  <= idx + ADDR_W'(1);
        left <= left - 3'd1;
      end
      if (beat_valid) pend <= 1'b0;
      if (word_valid) begin
        case (phase)
          PH_HDR: begin
            cfg_word <= word;
            if (hdr_ok) begin
              wide16 <= want16;
              idx    <= want16 ? HALF_START : BYTE_START;
              left   <= want16 ? 3'd2 : 3'd4;
              phase  <= PH_MAGIC;
            end else begin
              status <= ST_HDR_BAD;
              err    <= 1'b1;
              phase  <= PH_FAIL;
            end
          end
          PH_MAGIC: begin
            if (word == BOOT_MAGIC) begin
              left  <= beats;
              phase <= PH_OP;
            end else begin
              status <= ST_MAGIC_BAD;
              err    <= 1'b1;
              phase  <= PH_FAIL;
            end
          end
          PH_OP: begin
            op_data <= word;
            done    <= 1'b1;
            phase   <= PH_OFFER;
          end
          default: ;
        endcase
      end
      if (phase == PH_OFFER && op_ready) phase <= PH_DONE;
    end
  end

  assign op_valid = (phase == PH_OFFER);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && $stable(status)));
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !err));
  assert_offer_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_data)));
  assert_quiet_after_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> fl_cs_n);
  assert_clean_header_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MAGIC) |-> ((cfg_word & HDR_RSVD_MASK) == '0));
endmodule

// File: tb/tb_nor_hdr_loader.sv
module tb_nor_hdr_loader;
  localparam int ADDR_W = 16;
  localparam int WAIT_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [WAIT_W-1:0] wait_cycles = '0;
  logic              fl_cs_n;
  logic [ADDR_W-1:0] fl_addr;
  logic [15:0]       fl_rdata;
  logic [31:0]       cfg_word, op_data, status;
  logic              wide16, op_valid, done, err;
  logic              op_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  nor_hdr_loader #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wait_cycles(wait_cycles), .fl_cs_n(fl_cs_n),
    .fl_addr(fl_addr), .fl_rdata(fl_rdata), .cfg_word(cfg_word), .wide16(wide16),
    .op_valid(op_valid), .op_ready(op_ready), .op_data(op_data), .done(done),
    .err(err), .status(status)
  );

  always #10 clk = ~clk;

  logic [15:0] rsp_seq [0:15];
  int          addr_log [0:15];
  int          acc_n;
  logic [63:0] exp_q [$];

  always @(negedge fl_cs_n or negedge rst_n) begin
    if (!rst_n) acc_n = 0;
    else begin
      if (acc_n < 16) addr_log[acc_n] = int'(fl_addr);
      acc_n = acc_n + 1;
    end
  end

  assign fl_rdata = (acc_n > 0 && acc_n <= 16) ? rsp_seq[acc_n-1] : 16'hFFFF;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard pops on command handshake or on error rise
  logic err_d = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) err_d = 1'b0;
    else begin
      if (op_valid && op_ready) begin
        logic [63:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hDEAD;
        chk(e == {32'h0, op_data}, "R7", "accepted command word", {32'h0, op_data}, e);
      end
      if (err && !err_d) begin
        logic [63:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hDEAD;
        chk(e == {status, 32'h0}, "R9", "error status", {status, 32'h0}, e);
      end
      err_d = err;
    end
  end

  // Strobe length monitor
  int run = 0;
  always @(negedge clk) begin
    if (!fl_cs_n) run++;
    else if (run > 0) begin
      chk(run == int'(wait_cycles) + 1, "R8", "strobe length", 64'(run), 64'(int'(wait_cycles) + 1));
      run = 0;
    end
  end

  task automatic put_bytes(input int k, input logic [31:0] w);
    for (int i = 0; i < 4; i++) rsp_seq[k+i] = {8'hFF, w[8*i +: 8]};
  endtask

  task automatic put_halves(input int k, input logic [31:0] w);
    rsp_seq[k]   = w[15:0];
    rsp_seq[k+1] = w[31:16];
  endtask

  task automatic run_case(input string name, input int w, input bit bp,
                          input logic [31:0] e_cfg, input logic [31:0] e_status,
                          input logic [31:0] e_op, input bit e_wide, input int e_acc);
    int t;
    @(posedge clk); #2;
    rst_n = 1'b0;
    wait_cycles = WAIT_W'(w);
    op_ready = !bp;
    exp_q.delete();
    repeat (3) @(posedge clk);
    #2;
    exp_q.push_back(e_status == 0 ? {32'h0, e_op} : {e_status, 32'h0});
    rst_n = 1'b1;
    t = 0;
    while (!(done || err) && t < 3000) begin @(posedge clk); t++; end
    #2;
    if (bp) begin
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk(op_valid && op_data == e_op, "R7", {name, " held under back-pressure"},
            {31'h0, op_valid, op_data}, {32'h1, e_op});
      end
      @(posedge clk); #2;
      op_ready = 1'b1;
    end
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(status == e_status, e_status == 5 ? "R4" : (e_status == 6 ? "R6" : "R9"),
        {name, " status"}, 64'(status), 64'(e_status));
    chk(err == (e_status != 0) && done == (e_status == 0), "R9", {name, " done/err"},
        {62'h0, done, err}, {62'h0, e_status == 0, e_status != 0});
    chk(cfg_word == e_cfg, "R2", {name, " cfg_word"}, 64'(cfg_word), 64'(e_cfg));
    if (e_status != 5)
      chk(wide16 == e_wide, "R3", {name, " width"}, 64'(wide16), 64'(e_wide));
    chk(acc_n == e_acc, e_status == 0 ? "R3" : "R4", {name, " access count"},
        64'(acc_n), 64'(e_acc));
    for (int i = 0; i < e_acc && i < acc_n && i < 16; i++) begin
      int ea;
      ea = (i < 4) ? i : (e_wide ? 2 + (i - 4) : i);
      chk(addr_log[i] == ea, i < 4 ? "R1" : "R3", {name, " address"},
          64'(addr_log[i]), 64'(ea));
    end
    chk(exp_q.size() == 0, "R7", {name, " scoreboard drained"}, 64'(exp_q.size()), 64'h0);
    chk(fl_cs_n == 1'b1 && op_valid == 1'b0, "R7", {name, " idle at end"},
        {62'h0, fl_cs_n, op_valid}, 64'h2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rsp_seq[i] = 16'hFFFF;
    repeat (2) @(negedge clk);
    chk(fl_cs_n && !done && !err && !op_valid && status == 0, "R9", "reset state",
        {status, 28'h0, fl_cs_n, done, err, op_valid}, 64'h8);

    // 16-bit flash, upper lane pulled high during header (R1 ignores it)
    put_bytes(0, 32'h0000_0021);
    put_halves(4, 32'h4150_4954);
    put_halves(6, 32'h5853_590D);
    run_case("wide16", 0, 1'b0, 32'h21, 0, 32'h5853_590D, 1'b1, 8);

    // 8-bit flash, wait states, back-pressure on the command word
    put_bytes(0, 32'h0000_0020);
    put_bytes(4, 32'h4150_4954);
    put_bytes(8, 32'h5853_590D);
    run_case("byte8", 3, 1'b1, 32'h20, 0, 32'h5853_590D, 1'b0, 12);

    // R5: method and copy fields set, still accepted
    put_bytes(0, 32'h0000_0F31);
    put_halves(4, 32'h4150_4954);
    put_halves(6, 32'h1234_ABCD);
    run_case("R5 method/copy", 1, 1'b0, 32'hF31, 0, 32'h1234_ABCD, 1'b1, 8);

    // R4: duplicated low bytes
    put_bytes(0, 32'h0000_2121);
    run_case("R4 dup bytes", 0, 1'b0, 32'h2121, 5, 0, 1'b0, 4);

    // R4: pulled-up upper half
    put_bytes(0, 32'hFFFF_0021);
    run_case("R4 pull-up", 2, 1'b0, 32'hFFFF_0021, 5, 0, 1'b0, 4);

    // R4: single reserved bits in the low byte
    put_bytes(0, 32'h0000_0023);
    run_case("R4 bit1", 0, 1'b0, 32'h23, 5, 0, 1'b0, 4);
    put_bytes(0, 32'h0000_0061);
    run_case("R4 bit6", 0, 1'b0, 32'h61, 5, 0, 1'b0, 4);

    // R6: marker mismatch in 16-bit mode
    put_bytes(0, 32'h0000_0021);
    put_halves(4, 32'h4150_4955);
    run_case("R6 bad marker", 0, 1'b0, 32'h21, 6, 0, 1'b1, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule